// File: doc/BRIEF.md
# PLL Lock Monitor

This block decides whether a phase-locked loop is in lock by looking at the rising edges of two divider outputs: the reference divider and the feedback divider. A fast sampling clock counts the cycles between matching edges. Each completed pair of edges is one comparison. The measured separation is compared against one of four lock windows, chosen by a 2-bit window select. It does not matter which divider's edge arrives first.

An out-of-window comparison raises the unlock flag at once, drops the lock flag and restarts the run of good comparisons. An in-window comparison clears the unlock flag at once. The lock flag rises only after an unbroken run of in-window comparisons, of a length chosen by a 2-bit run select. A status pin carries either flag, depending on a select input. All pins are plain levels or single-cycle pulses. The block has no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `lk_en` is 0, `lock` and `unlock` are both 0 one cycle later, and comparisons made during that time have no effect.
- R2: The window select maps 0/1/2/3 to 3/10/30/90 ns. This becomes a threshold of floor(window_ps / SAMPLE_PS) sampling cycles, which is 0/2/6/18 at the default 5000 ps. A comparison is in window when the edge separation in sampling cycles is at or below the threshold.
- R3: The run select maps 0/1/2/3 to 32/128/512/2048 consecutive in-window comparisons.
- R4: `lock` rises only when an in-window comparison completes the selected run. It stays 0 after one comparison fewer.
- R5: An out-of-window comparison sets `unlock` to 1 and `lock` to 0 in the same update, and restarts the run from zero. `lock` and `unlock` are never both 1.
- R6: `unlock` returns to 0 on the first in-window comparison, without waiting for the run.
- R7: A reference edge leading the feedback edge by k cycles gives the same result as one lagging it by k cycles.
- R8: If a second rising edge of one divider arrives before any edge of the other, the comparison counts as out of window. The new edge then starts the next measurement.
- R9: A change of the window select or the run select while enabled clears `lock` and restarts the run.
- R10: `stat` equals `lock` when `stat_sel` is 0 and equals `unlock` when `stat_sel` is 1.
- R11: After reset, `lock` and `unlock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all edges are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference divider output; rising edges are used |
| fb_pulse | input | 1 | Feedback divider output; rising edges are used |
| lk_en | input | 1 | Enables the detector |
| win_sel | input | 2 | Lock window select |
| cnt_sel | input | 2 | Required run length select |
| stat_sel | input | 1 | Picks the flag shown on `stat` |
| lock | output | 1 | Lock flag |
| unlock | output | 1 | Unlock flag |
| stat | output | 1 | Selected flag |

## Verification
A wrong run counter shows up at the ports as `lock` rising one comparison too early or too late. It is seen two sampling cycles after the comparison that should have completed the run. A corrupted measurement state or a wrong threshold makes `unlock` wrong on the next comparison, so edge separations are swept across each threshold in both directions. A missed configuration change leaves `lock` high two cycles after a select input has moved.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  typedef enum logic [1:0] {
    PM_IDLE     = 2'd0,
    PM_WAIT_FB  = 2'd1,
    PM_WAIT_REF = 2'd2
  } pm_state_t;

  // lock window in picoseconds for each window select code
  function automatic int unsigned window_ps(input int unsigned code);
    case (code)
      0:       return 3000;
      1:       return 10000;
      2:       return 30000;
      default: return 90000;
    endcase
  endfunction

  // consecutive comparisons needed for each run select code
  function automatic int unsigned run_length(input int unsigned code,
                                             input int unsigned base_log2);
    return 32'd1 << (base_log2 + 2 * code);
  endfunction

endpackage

// File: rtl/edge_phase_meter.sv
module edge_phase_meter
  import pll_lock_pkg::*;
#(
  parameter int unsigned MEAS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pulse,
  input  logic              fb_pulse,
  output logic              meas_valid,
  output logic [MEAS_W-1:0] meas_cycles,
  output logic              meas_sat
);

  localparam logic [MEAS_W-1:0] CNT_MAX = '1;

  logic [1:0] pulse_in;
  logic [1:0] pulse_q;
  logic [1:0] rise;

  assign pulse_in = {fb_pulse, ref_pulse};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[g] <= 1'b0;
      else        pulse_q[g] <= pulse_in[g];
    end
    assign rise[g] = pulse_in[g] & ~pulse_q[g];
  end

  pm_state_t         state;
  logic [MEAS_W-1:0] cnt;
  logic              first_is_fb;
  logic              same_rise;
  logic              other_rise;

  // which divider opened the current measurement
  assign first_is_fb = (state == PM_WAIT_REF);
  assign same_rise   = first_is_fb ? rise[1] : rise[0];
  assign other_rise  = first_is_fb ? rise[0] : rise[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PM_IDLE;
      cnt         <= '0;
      meas_valid  <= 1'b0;
      meas_cycles <= '0;
      meas_sat    <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      if (state == PM_IDLE) begin
        if (&rise) begin
          meas_valid  <= 1'b1;
          meas_cycles <= '0;
          meas_sat    <= 1'b0;
        end else if (rise[0]) begin
          state <= PM_WAIT_FB;
          cnt   <= MEAS_W'(1);
        end else if (rise[1]) begin
          state <= PM_WAIT_REF;
          cnt   <= MEAS_W'(1);
        end
      end else begin
        if (other_rise) begin
          meas_valid  <= 1'b1;
          meas_cycles <= cnt;
          meas_sat    <= (cnt == CNT_MAX);
          state       <= PM_IDLE;
        end else if (same_rise) begin
          // repeated edge before the partner: report a saturated result
          meas_valid  <= 1'b1;
          meas_cycles <= CNT_MAX;
          meas_sat    <= 1'b1;
          cnt         <= MEAS_W'(1);
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lock_run_tracker.sv
module lock_run_tracker #(
  parameter int unsigned MEAS_W = 8,
  parameter int unsigned RUN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [1:0]        win_sel,
  input  logic [1:0]        cnt_sel,
  input  logic              meas_valid,
  input  logic [MEAS_W-1:0] meas_cycles,
  input  logic              meas_sat,
  input  logic [MEAS_W-1:0] thr_cycles,
  input  logic [RUN_W-1:0]  run_len,
  output logic              meas_hit,
  output logic              lock,
  output logic              unlock
);

  logic [1:0]       win_q;
  logic [1:0]       cnt_q;
  logic             cfg_chg;
  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] run_inc;

  assign meas_hit = meas_valid && !meas_sat && (meas_cycles <= thr_cycles);
  assign cfg_chg  = (win_sel != win_q) || (cnt_sel != cnt_q);
  assign run_inc  = run + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 2'd0;
      cnt_q <= 2'd0;
    end else begin
      win_q <= win_sel;
      cnt_q <= cnt_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      lock   <= 1'b0;
      unlock <= 1'b0;
    end else if (!lk_en) begin
      run    <= '0;
      lock   <= 1'b0;
      unlock <= 1'b0;
    end else if (meas_valid && !meas_hit) begin
      run    <= '0;
      lock   <= 1'b0;
      unlock <= 1'b1;
    end else if (cfg_chg) begin
      run  <= '0;
      lock <= 1'b0;
      if (meas_valid) unlock <= 1'b0;
    end else if (meas_valid) begin
      unlock <= 1'b0;
      if (run < run_len) run <= run_inc;
      if (run_inc >= run_len) lock <= 1'b1;
    end
  end

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int unsigned SAMPLE_PS     = 5000,
  parameter int unsigned MEAS_W        = 8,
  parameter int unsigned RUN_BASE_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic       fb_pulse,
  input  logic       lk_en,
  input  logic [1:0] win_sel,
  input  logic [1:0] cnt_sel,
  input  logic       stat_sel,
  output logic       lock,
  output logic       unlock,
  output logic       stat
);

  localparam int unsigned RUN_W    = RUN_BASE_LOG2 + 7;
  localparam int unsigned THR_CAP  = (1 << MEAS_W) - 2;

  logic [MEAS_W-1:0] thr_tab [4];
  logic [RUN_W-1:0]  run_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_tab
    localparam int unsigned TC = window_ps(g) / SAMPLE_PS;
    localparam int unsigned TL = (TC > THR_CAP) ? THR_CAP : TC;
    assign thr_tab[g] = MEAS_W'(TL);
    assign run_tab[g] = RUN_W'(run_length(g, RUN_BASE_LOG2));
  end

  logic              meas_valid;
  logic [MEAS_W-1:0] meas_cycles;
  logic              meas_sat;
  logic              meas_hit;

  edge_phase_meter #(.MEAS_W(MEAS_W)) i_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_pulse   (ref_pulse),
    .fb_pulse    (fb_pulse),
    .meas_valid  (meas_valid),
    .meas_cycles (meas_cycles),
    .meas_sat    (meas_sat)
  );

  lock_run_tracker #(.MEAS_W(MEAS_W), .RUN_W(RUN_W)) i_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_en       (lk_en),
    .win_sel     (win_sel),
    .cnt_sel     (cnt_sel),
    .meas_valid  (meas_valid),
    .meas_cycles (meas_cycles),
    .meas_sat    (meas_sat),
    .thr_cycles  (thr_tab[win_sel]),
    .run_len     (run_tab[cnt_sel]),
    .meas_hit    (meas_hit),
    .lock        (lock),
    .unlock      (unlock)
  );

  assign stat = stat_sel ? unlock : lock;

endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_en,
  input logic [1:0] win_sel,
  input logic [1:0] cnt_sel,
  input logic       meas_valid,
  input logic       meas_hit,
  input logic       lock,
  input logic       unlock
);

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> (!lock && !unlock));

  assert_lock_after_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(meas_valid && meas_hit));

  assert_miss_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && meas_valid && !meas_hit) |=> (unlock && !lock));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock && unlock));

  assert_hit_clears_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && meas_valid && meas_hit) |=> !unlock);

  assert_cfg_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && lk_en && (win_sel != $past(win_sel) || cnt_sel != $past(cnt_sel)))
      |=> !lock);

endmodule

bind pll_lock_monitor pll_lock_monitor_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_en      (lk_en),
  .win_sel    (win_sel),
  .cnt_sel    (cnt_sel),
  .meas_valid (meas_valid),
  .meas_hit   (meas_hit),
  .lock       (lock),
  .unlock     (unlock)
);

// File: tb/test_pll_lock_monitor.sv
module test_pll_lock_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_pulse = 1'b0;
  logic       fb_pulse = 1'b0;
  logic       lk_en = 1'b0;
  logic [1:0] win_sel = 2'd0;
  logic [1:0] cnt_sel = 2'd0;
  logic       stat_sel = 1'b0;
  logic       lock;
  logic       unlock;
  logic       stat;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the flags
  int  m_run = 0;
  bit  m_lock = 1'b0;
  bit  m_unlock = 1'b0;

  always #2.5 clk = ~clk;

  pll_lock_monitor i_pll_lock_monitor (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .lk_en(lk_en), .win_sel(win_sel), .cnt_sel(cnt_sel), .stat_sel(stat_sel),
    .lock(lock), .unlock(unlock), .stat(stat)
  );

  function automatic int thr_of(input int sel);
    int ps;
    case (sel)
      0: ps = 3000;
      1: ps = 10000;
      2: ps = 30000;
      default: ps = 90000;
    endcase
    return ps / 5000;
  endfunction

  function automatic int len_of(input int sel);
    return 32 << (2 * sel);
  endfunction

  task automatic model_result(input bit hit);
    if (!lk_en) begin
      m_run = 0; m_lock = 0; m_unlock = 0;
    end else if (!hit) begin
      m_run = 0; m_lock = 0; m_unlock = 1;
    end else begin
      m_unlock = 0;
      if (m_run < len_of(cnt_sel)) m_run++;
      if (m_run >= len_of(cnt_sel)) m_lock = 1;
    end
  endtask

  task automatic check(input string req, input bit el, input bit eu);
    bit es;
    es = stat_sel ? eu : el;
    checks++;
    if (lock !== el || unlock !== eu || stat !== es) begin
      failures++;
      $display("FAIL %s: lock/unlock/stat=%0b%0b%0b expected %0b%0b%0b",
               req, lock, unlock, stat, el, eu, es);
    end
  endtask

  // one comparison: first edge, then the partner sep cycles later
  task automatic do_cmp(input bit ref_first, input int sep);
    @(negedge clk);
    if (sep == 0) begin
      ref_pulse = 1; fb_pulse = 1;
    end else begin
      if (ref_first) ref_pulse = 1; else fb_pulse = 1;
      for (int k = 1; k <= sep; k++) begin
        @(negedge clk);
        ref_pulse = 0; fb_pulse = 0;
        if (k == sep) begin
          if (ref_first) fb_pulse = 1; else ref_pulse = 1;
        end
      end
    end
    @(negedge clk);
    ref_pulse = 0; fb_pulse = 0;
    repeat (3) @(negedge clk);
    model_result(sep <= thr_of(win_sel));
  endtask

  task automatic set_cfg(input int w, input int c);
    @(negedge clk);
    if (lk_en && (w != win_sel || c != cnt_sel)) begin
      m_run = 0; m_lock = 0;
    end
    win_sel = 2'(w); cnt_sel = 2'(c);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (4) @(negedge clk);
    check("R11 reset", 0, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: disabled, misses have no effect
    do_cmp(1, 10);
    check("R1 disabled miss", 0, 0);
    lk_en = 1;
    @(negedge clk);

    // R2 window 0: threshold 0 cycles
    set_cfg(0, 0);
    do_cmp(1, 0);  check("R2 sel0 sep0 hit", m_lock, m_unlock);
    do_cmp(1, 1);  check("R2 sel0 sep1 miss", 0, 1);
    // R6 unlock clears on next hit
    do_cmp(0, 0);  check("R6 unlock clears", 0, 0);

    // R2 window boundaries and R7 symmetry
    for (int w = 1; w < 4; w++) begin
      set_cfg(w, 0);
      do_cmp(1, thr_of(w));     check("R2 at threshold", m_lock, 0);
      do_cmp(0, thr_of(w));     check("R7 lag at threshold", m_lock, 0);
      do_cmp(1, thr_of(w) + 1); check("R2 above threshold", 0, 1);
      do_cmp(0, thr_of(w) + 1); check("R7 lag above threshold", 0, 1);
    end

    // R3/R4 run lengths for every count select
    for (int c = 0; c < 4; c++) begin
      set_cfg(3, c);
      do_cmp(1, 30);
      check("R5 miss before run", 0, 1);
      for (int i = 0; i < len_of(c) - 1; i++) do_cmp(i[0], 0);
      check("R4 one short of run", 0, 0);
      do_cmp(1, 2);
      check("R3 run complete", 1, 0);
      stat_sel = 1; #1;
      check("R10 stat shows unlock", 1, 0);
      stat_sel = 0; #1;
      check("R10 stat shows lock", 1, 0);
    end

    // R5: a miss while locked
    do_cmp(0, 19);
    check("R5 miss clears lock", 0, 1);
    stat_sel = 1; #1;
    check("R10 stat unlock", 0, 1);
    stat_sel = 0;

    // R9: lock then change a select
    set_cfg(3, 0);
    for (int i = 0; i < 32; i++) do_cmp(1, 1);
    check("R4 locked again", 1, 0);
    set_cfg(2, 0);
    check("R9 window change clears lock", 0, 0);
    for (int i = 0; i < 31; i++) do_cmp(0, 3);
    check("R9 run restarted", 0, 0);
    do_cmp(0, 3);
    check("R9 relock", 1, 0);
    set_cfg(2, 1);
    check("R9 count change clears lock", 0, 0);

    // R8: repeated reference edge before any feedback edge
    set_cfg(2, 0);
    @(negedge clk); ref_pulse = 1;
    @(negedge clk); ref_pulse = 0;
    repeat (2) @(negedge clk); ref_pulse = 1;
    @(negedge clk); ref_pulse = 0;
    repeat (2) @(negedge clk);
    model_result(0);
    check("R8 repeated edge is a miss", 0, 1);
    fb_pulse = 1;
    @(negedge clk); fb_pulse = 0;
    repeat (3) @(negedge clk);
    model_result(1);
    check("R8 partner closes measurement", 0, 0);

    // R1: disable while locked, then enable
    for (int i = 0; i < 32; i++) do_cmp(1, 0);
    check("R4 locked before disable", 1, 0);
    lk_en = 0;
    @(negedge clk); @(negedge clk);
    model_result(1);
    check("R1 disable clears", 0, 0);
    do_cmp(0, 40);
    check("R1 miss ignored", 0, 0);
    lk_en = 1;
    @(negedge clk);

    // random mix with model
    for (int i = 0; i < 400; i++) begin
      int sep;
      if (i % 60 == 0) set_cfg($urandom_range(1, 3), 0);
      sep = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 22)
                                        : $urandom_range(0, thr_of(win_sel));
      do_cmp($urandom_range(0, 1) == 1, sep);
      check("R5/R6 random mix", m_lock, m_unlock);
    end

    finish_run();
  end

endmodule